// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Atomic Output Update

This block is a 32-pin general-purpose I/O port on a simple 32-bit register bus. The bus has an address, a write strobe with write data, and a read strobe with read data. Internally the port keeps an output latch, which drives the pin output values. It also keeps a direction mask, which drives the per-pin output enables, and it samples the pin levels through a two-flop synchronizer. Every register has one bit per pin.

Software can load the output latch directly. It can also change selected bits without a read-modify-write sequence, through three alias addresses: one sets bits, one clears bits and one inverts bits, in each case only the bits whose write-data bit is 1. Reads are registered. A read and a write issued in the same cycle see the register contents from before the write. Interrupts, pin multiplexing, pulls and drive strength belong to other blocks.

Top module: `gpio_port`

## Requirements
- R1: After reset the output latch and the direction mask are all zeros, so `pin_oe` and `pin_out` are 0 and `bus_rdata` is 0.
- R2: A write to byte offset 0x00 loads the output latch with `bus_wdata`, and a read of 0x00 returns the latch.
- R3: A write to offset 0x04 sets every latch bit whose `bus_wdata` bit is 1 and leaves the other bits unchanged.
- R4: A write to offset 0x08 clears every latch bit whose `bus_wdata` bit is 1 and leaves the other bits unchanged.
- R5: A write to offset 0x0C inverts every latch bit whose `bus_wdata` bit is 1 and leaves the other bits unchanged.
- R6: Offset 0x14 holds the direction mask: bit n = 1 makes pin n an output (`pin_oe[n]`=1), and bit n = 0 makes it an input. The mask is readable, and `pin_oe` changes only after a write to 0x14.
- R7: A read of offset 0x10 returns `pin_in` after a two-flop synchronizer. A level that is applied before the clock edge on which a read is issued appears in the data of the third read from that edge. Writes to 0x10 have no effect.
- R8: Reads of offsets 0x04, 0x08 and 0x0C return zero.
- R9: Read data appears on `bus_rdata` one cycle after `bus_re` and is held until the next read. A read in the same cycle as a write returns the value from before the write.
- R10: Addresses outside the six offsets read as zero, and writes to them change neither the latch nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pin levels (asynchronous) |
| pin_out | output | 32 | Output latch value |
| pin_oe | output | 32 | Per-pin output enable |

## Verification
Two functions can fall in the same cycle: a register read and a write to the same register. The bench provokes this with single bus cycles that assert both strobes at the data, set and direction offsets. The scoreboard expects the value from before the write, and a follow-up read expects the new value. The synchronizer latency is judged the same way: a pin change is followed by three back-to-back reads of the input register, which must return old, old, new.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int OFF_DATA = 'h00;
  localparam int OFF_SET  = 'h04;
  localparam int OFF_CLR  = 'h08;
  localparam int OFF_TOG  = 'h0C;
  localparam int OFF_IN   = 'h10;
  localparam int OFF_DIR  = 'h14;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_LOAD = 3'd1,
    OP_SET  = 3'd2,
    OP_CLR  = 3'd3,
    OP_TOG  = 3'd4
  } latch_op_e;

  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_DATA = 2'd1,
    SEL_IN   = 2'd2,
    SEL_DIR  = 2'd3
  } rd_sel_e;

  function automatic logic [31:0] apply_op(input latch_op_e op,
                                           input logic [31:0] cur,
                                           input logic [31:0] mask);
    logic [31:0] nxt;
    case (op)
      OP_LOAD: nxt = mask;
      OP_SET:  nxt = cur | mask;
      OP_CLR:  nxt = cur & ~mask;
      OP_TOG:  nxt = cur ^ mask;
      default: nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/gpio_latch.sv
module gpio_latch
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  latch_op_e        op,
  input  logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_next;
  logic             op_active;

  assign q_next    = WIDTH'(apply_op(op, 32'(q), 32'(mask)));
  assign op_active = (op != OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  // R2: a load takes the written word as is
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD) |=> (q == $past(mask)));

  // R3: selected bits become 1, the others keep their value
  assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SET) |=> (((q & $past(mask)) == $past(mask)) &&
                        ((q & ~$past(mask)) == ($past(q) & ~$past(mask)))));

  // R4: selected bits become 0, the others keep their value
  assert_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CLR) |=> (((q & $past(mask)) == '0) &&
                        ((q & ~$past(mask)) == ($past(q) & ~$past(mask)))));

  // R5: exactly the selected bits differ from the previous value
  assert_tog_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_TOG) |=> ((q ^ $past(q)) == $past(mask)));

  // R10: without an operation the register holds
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_active |=> $stable(q));

endmodule

// File: rtl/gpio_readmux.sv
module gpio_readmux
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  rd_sel_e          sel,
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] in_q,
  input  logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] rd_word;

  always_comb begin
    case (sel)
      SEL_DATA: rd_word = data_q;
      SEL_IN:   rd_word = in_q;
      SEL_DIR:  rd_word = dir_q;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end

  // R9: read data holds between reads
  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  // R8 / R10: alias and unmapped reads give zero
  assert_zero_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_ZERO) |=> (rdata == '0));

  // R9: a data read reflects the latch as it was before that edge
  assert_rd_old_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_DATA) |=> (rdata == $past(data_q)));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int PINS        = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [PINS-1:0]   bus_wdata,
  input  logic              bus_re,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFF_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFF_CLR);
  localparam logic [ADDR_W-1:0] A_TOG  = ADDR_W'(OFF_TOG);
  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFF_IN);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFF_DIR);

  latch_op_e        data_op;
  latch_op_e        dir_op;
  rd_sel_e          rd_sel;
  logic             dir_hit;
  logic [PINS-1:0]  data_q;
  logic [PINS-1:0]  dir_q;
  logic [PINS-1:0]  in_sync;

  // write decode
  always_comb begin
    data_op = OP_NONE;
    dir_op  = OP_NONE;
    if (bus_we) begin
      case (bus_addr)
        A_DATA:  data_op = OP_LOAD;
        A_SET:   data_op = OP_SET;
        A_CLR:   data_op = OP_CLR;
        A_TOG:   data_op = OP_TOG;
        A_DIR:   dir_op  = OP_LOAD;
        default: ;
      endcase
    end
  end

  assign dir_hit = (dir_op != OP_NONE);

  // read decode
  always_comb begin
    case (bus_addr)
      A_DATA:  rd_sel = SEL_DATA;
      A_IN:    rd_sel = SEL_IN;
      A_DIR:   rd_sel = SEL_DIR;
      default: rd_sel = SEL_ZERO;
    endcase
  end

  gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_in),
    .q_sync  (in_sync)
  );

  gpio_latch #(.WIDTH(PINS)) out_latch_i (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (data_op),
    .mask  (bus_wdata),
    .q     (data_q)
  );

  gpio_latch #(.WIDTH(PINS)) dir_latch_i (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (dir_op),
    .mask  (bus_wdata),
    .q     (dir_q)
  );

  gpio_readmux #(.WIDTH(PINS)) rd_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (bus_re),
    .sel    (rd_sel),
    .data_q (data_q),
    .in_q   (in_sync),
    .dir_q  (dir_q),
    .rdata  (bus_rdata)
  );

  assign pin_out = data_q;
  assign pin_oe  = dir_q;

  // R1: leaving reset, latch and mask are clear
  assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_out == '0 && pin_oe == '0));

  // R6: output enables move only on a direction write
  assert_dir_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_hit |=> $stable(pin_oe));

  // R6: a direction write lands on the enables
  assert_dir_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dir_hit |=> (pin_oe == $past(bus_wdata)));

  // R7 / R10: writes to the input or unmapped offsets leave the outputs alone
  assert_no_side_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == A_IN || bus_addr > A_DIR)) |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;

  localparam logic [7:0] AD_DATA = 8'h00;
  localparam logic [7:0] AD_SET  = 8'h04;
  localparam logic [7:0] AD_CLR  = 8'h08;
  localparam logic [7:0] AD_TOG  = 8'h0C;
  localparam logic [7:0] AD_IN   = 8'h10;
  localparam logic [7:0] AD_DIR  = 8'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  logic [31:0] m_out = '0;
  logic [31:0] m_dir = '0;
  logic        re_q = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  gpio_port dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(input logic [7:0] a);
    case (a)
      AD_DATA: return m_out;
      AD_DIR:  return m_dir;
      default: return 32'h0;
    endcase
  endfunction

  // one bus cycle; the read expectation is taken before the write lands
  task automatic bus_op(input logic we, input logic re, input logic [7:0] a,
                        input logic [31:0] d, input string tag,
                        input logic use_exp = 1'b0, input logic [31:0] exp = '0);
    sb_item_t it;
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d;
    if (re) begin
      it.exp = use_exp ? exp : model_rd(a);
      it.tag = tag;
      sb_q.push_back(it);
    end
    if (we) begin
      case (a)
        AD_DATA: m_out = d;
        AD_SET:  m_out = m_out | d;
        AD_CLR:  m_out = m_out & ~d;
        AD_TOG:  m_out = m_out ^ d;
        AD_DIR:  m_dir = d;
        default: ;
      endcase
    end
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
  endtask

  // monitor: pops one expectation per completed read
  always @(posedge clk) re_q <= bus_re;

  always @(negedge clk) begin
    if (re_q) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected read data actual=%08h expected=none", bus_rdata);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        check(it.tag, bus_rdata, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pin_out in reset", pin_out, 32'h0);
    check("R1 pin_oe in reset", pin_oe, 32'h0);
    check("R1 rdata in reset", bus_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    bus_op(1'b0, 1'b1, AD_DIR, '0, "R1 dir after reset");

    // R2 direct load
    bus_op(1'b1, 1'b0, AD_DATA, 32'hA5A5_0F0F, "");
    check("R2 pin_out after load", pin_out, 32'hA5A5_0F0F);
    bus_op(1'b0, 1'b1, AD_DATA, '0, "R2 read data");

    // R3, R4, R5 atomic updates
    bus_op(1'b1, 1'b0, AD_SET, 32'h0000_F0F0, "");
    check("R3 set", pin_out, 32'hA5A5_FFFF);
    bus_op(1'b1, 1'b0, AD_CLR, 32'hA000_000F, "");
    check("R4 clear", pin_out, 32'h05A5_FFF0);
    bus_op(1'b1, 1'b0, AD_TOG, 32'hFFFF_0000, "");
    check("R5 toggle", pin_out, 32'hFA5A_FFF0);
    bus_op(1'b1, 1'b0, AD_TOG, 32'hFFFF_0000, "");
    check("R5 toggle back", pin_out, 32'h05A5_FFF0);
    bus_op(1'b0, 1'b1, AD_DATA, '0, "R5 read after toggles");
    // back-to-back set then clear of overlapping bits
    bus_op(1'b1, 1'b0, AD_SET, 32'h0F00_0000, "");
    bus_op(1'b1, 1'b0, AD_CLR, 32'h0300_0000, "");
    check("R4 clear after set", pin_out, 32'h0CA5_FFF0);

    // R6 direction
    bus_op(1'b1, 1'b0, AD_DIR, 32'h00FF_00FF, "");
    check("R6 pin_oe", pin_oe, 32'h00FF_00FF);
    bus_op(1'b0, 1'b1, AD_DIR, '0, "R6 read dir");
    bus_op(1'b1, 1'b0, AD_SET, 32'hFFFF_FFFF, "");
    check("R6 oe unaffected by set", pin_oe, 32'h00FF_00FF);

    // R8 alias reads
    bus_op(1'b0, 1'b1, AD_SET, '0, "R8 set reads zero");
    bus_op(1'b0, 1'b1, AD_CLR, '0, "R8 clear reads zero");
    bus_op(1'b0, 1'b1, AD_TOG, '0, "R8 toggle reads zero");

    // R7 input sampling latency: old, old, new
    pin_in = 32'h1234_5678;
    repeat (3) @(negedge clk);
    bus_op(1'b0, 1'b1, AD_IN, '0, "R7 settled input", 1'b1, 32'h1234_5678);
    pin_in = 32'hCAFE_0001;
    bus_op(1'b0, 1'b1, AD_IN, '0, "R7 latency first", 1'b1, 32'h1234_5678);
    bus_op(1'b0, 1'b1, AD_IN, '0, "R7 latency second", 1'b1, 32'h1234_5678);
    bus_op(1'b0, 1'b1, AD_IN, '0, "R7 latency third", 1'b1, 32'hCAFE_0001);
    bus_op(1'b1, 1'b0, AD_IN, 32'hFFFF_FFFF, "");
    bus_op(1'b0, 1'b1, AD_IN, '0, "R7 input after write", 1'b1, 32'hCAFE_0001);
    bus_op(1'b0, 1'b1, AD_DATA, '0, "R7 data untouched by input write");
    bus_op(1'b0, 1'b1, AD_DIR, '0, "R7 dir untouched by input write");

    // R9 same-cycle read and write
    bus_op(1'b1, 1'b1, AD_DATA, 32'h3C3C_3C3C, "R9 data read with write");
    bus_op(1'b0, 1'b1, AD_DATA, '0, "R9 data after write");
    bus_op(1'b1, 1'b1, AD_DIR, 32'hF0F0_0000, "R9 dir read with write");
    bus_op(1'b1, 1'b1, AD_SET, 32'h0000_0003, "R9 set read with write");
    bus_op(1'b0, 1'b1, AD_DATA, '0, "R9 data after set");
    repeat (3) @(negedge clk);
    check("R9 rdata held", bus_rdata, 32'h3C3C_3C3F);

    // R10 unmapped
    bus_op(1'b1, 1'b0, 8'h18, 32'hFFFF_FFFF, "");
    bus_op(1'b1, 1'b0, 8'h02, 32'h0000_0000, "");
    check("R10 pin_out after unmapped writes", pin_out, 32'h3C3C_3C3F);
    check("R10 pin_oe after unmapped writes", pin_oe, 32'hF0F0_0000);
    bus_op(1'b0, 1'b1, 8'h18, '0, "R10 unmapped read");
    bus_op(1'b0, 1'b1, 8'hFC, '0, "R10 high unmapped read");

    repeat (4) @(negedge clk);
    check("R9 scoreboard drained", 32'(sb_q.size()), 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule